// File: doc/BRIEF.md
# Command-Port Watchdog Controller

This block is a watchdog timer that a host programs through a byte-wide port with two addresses. The lower address carries data bytes and the upper address carries command bytes. Command bytes identify the block, open an indexed write to one of its delay bytes, and start, stop or refresh the countdown. An indexed write is a command byte followed by two data bytes: first the index, then the value.

Two 16-bit delays are kept. The enable delay is a grace period that runs after a start command. The reset delay is the countdown that the host must refresh with keep-alive commands. Both count ticks of a 100 ms clock-enable strobe, so a timeout of t seconds is programmed as 10·t (10 to 60000 ticks covers 1 s to 6000 s). When the countdown runs out, the block raises a one-cycle reset request, latches a timeout flag and stops.

Host accesses use a valid/ready request channel and a valid/ready read-response channel. A request is taken in a cycle where `req_valid` and `req_ready` are both high. A read places its byte on the response channel in the next cycle. That byte stays there until `rsp_ready` is seen high. `req_ready` stays low while a response is waiting, so the host can stall the block by holding `rsp_ready` low. The host normally leaves 10 ms between accesses, but the block accepts one access per cycle without losing state.

Top module: `cmdport_wdt`

## Requirements
- R1: `req_addr` 0 is the data address and 1 is the command address. A read of the command address always returns 0x00.
- R2: After command byte 0x30 (identify), every data-address read returns 0x95 until any other command byte is written. After that, data reads return 0x00.
- R3: Command 0x89 opens an indexed write. The next data write is the index and the one after it is the value. Index 0x5E/0x5F write the high/low byte of the reset delay, and 0x58/0x59 write the high/low byte of the enable delay. Any other index is ignored.
- R4: A command byte written while an indexed write is pending abandons it (0x89 starts a fresh one at the index stage). Data writes with no indexed write open are ignored.
- R5: Command 0x28 (start) clears the timeout flag. With an enable delay of zero the block arms at once. Otherwise it waits for enable-delay ticks and then loads the reset delay. Each cycle with `tick_100ms` high counts one tick, so the reset request follows the E+R-th tick (a reset delay of 0 acts as 1). A start, stop or effective keep-alive in the same cycle as a tick takes precedence and that tick is not counted.
- R6: `wdt_active` is high from a start until a stop or an expiry.
- R7: Command 0x2A (keep-alive) reloads the reset delay only while the countdown is armed. While stopped or during the enable wait it has no effect.
- R8: On expiry, `wdt_rst_req` is high for exactly one cycle, `wdt_timeout` becomes high and stays high until the next start, and `wdt_active` falls in the same cycle.
- R9: Command 0x29 (stop) takes effect in the next cycle and no reset request follows. A start while active restarts the whole sequence.
- R10: Delay bytes written while the countdown is armed do not alter it. The new value is used from the next keep-alive or start.
- R11: Any other command byte leaves the timer and delay registers unchanged.
- R12: A read taken in cycle n shows `rsp_valid` in cycle n+1. `rsp_valid` and `rsp_rdata` hold until a cycle with `rsp_ready` high, and no request is accepted meanwhile.
- R13: After reset the block is stopped, both delays are zero, `wdt_timeout`, `wdt_rst_req` and `rsp_valid` are low, and data reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_100ms | input | 1 | One-cycle strobe every 100 ms |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 1 | 0 data address, 1 command address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_rdata | output | 8 | Read byte |
| wdt_active | output | 1 | Watchdog started (enable wait or armed) |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| wdt_timeout | output | 1 | Latched expiry flag |

## Verification
The properties assume that the tick strobe and the request fields are clean synchronous levels. They also assume that a host holding `req_valid` keeps the write, address and byte fields steady, because the acceptance and response checks key on those fields in the cycle the request is taken. The stimulus changes every input only at the falling edge. It raises ticks only as single-cycle pulses between accesses and holds each request for a single accepted cycle. It also deliberately holds `rsp_ready` low with a request waiting, to exercise the stall.

// File: rtl/cmdport_wdt_pkg.sv
package cmdport_wdt_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] OP_IDENT   = 8'h30;
  localparam logic [7:0] OP_INDEXED = 8'h89;
  localparam logic [7:0] OP_START   = 8'h28;
  localparam logic [7:0] OP_STOP    = 8'h29;
  localparam logic [7:0] OP_REFRESH = 8'h2A;

  localparam logic [7:0] IX_GRACE_HI = 8'h58;
  localparam logic [7:0] IX_GRACE_LO = 8'h59;
  localparam logic [7:0] IX_LIMIT_HI = 8'h5E;
  localparam logic [7:0] IX_LIMIT_LO = 8'h5F;

  localparam logic [7:0] IDENT_BYTE = 8'h95;

  typedef enum logic [1:0] {TM_IDLE, TM_GRACE, TM_ARMED} tm_state_e;
  typedef enum logic [1:0] {IX_NONE, IX_WANT_INDEX, IX_WANT_VALUE} ix_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic refresh;
  } tm_cmd_t;
endpackage

// File: rtl/cmdport_wdt_port.sv
module cmdport_wdt_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] data_rd_byte,
  output logic              acc_fire,
  output logic              acc_write,
  output logic              acc_addr,
  output logic [DATA_W-1:0] acc_wdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              pend_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready = ~pend_q;
  assign acc_fire  = req_valid & req_ready;
  assign acc_write = req_write;
  assign acc_addr  = req_addr;
  assign acc_wdata = req_wdata;
  assign rsp_valid = pend_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      rdata_q <= '0;
    end else if (acc_fire && !req_write) begin
      pend_q  <= 1'b1;
      rdata_q <= req_addr ? '0 : data_rd_byte;
    end else if (pend_q && rsp_ready) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdport_wdt_decode.sv
module cmdport_wdt_decode
  import cmdport_wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DLY_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_write,
  input  logic              acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] data_rd_byte,
  output logic [DLY_W-1:0]  grace_dly,
  output logic [DLY_W-1:0]  limit_dly,
  output tm_cmd_t           tm_cmd
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              op_wr;
  logic              dat_wr;
  logic              ident_q;
  ix_state_e         ix_q;
  logic [DATA_W-1:0] index_q;
  logic              val_wr;

  assign op_wr  = acc_fire & acc_write & acc_addr;
  assign dat_wr = acc_fire & acc_write & ~acc_addr;
  assign val_wr = dat_wr & (ix_q == IX_WANT_VALUE);

  assign tm_cmd.start   = op_wr & (acc_wdata == DATA_W'(OP_START));
  assign tm_cmd.stop    = op_wr & (acc_wdata == DATA_W'(OP_STOP));
  assign tm_cmd.refresh = op_wr & (acc_wdata == DATA_W'(OP_REFRESH));

  assign data_rd_byte = ident_q ? DATA_W'(IDENT_BYTE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= 1'b0;
      ix_q    <= IX_NONE;
      index_q <= '0;
    end else if (op_wr) begin
      ident_q <= (acc_wdata == DATA_W'(OP_IDENT));
      ix_q    <= (acc_wdata == DATA_W'(OP_INDEXED)) ? IX_WANT_INDEX : IX_NONE;
    end else if (dat_wr) begin
      unique case (ix_q)
        IX_WANT_INDEX: begin
          index_q <= acc_wdata;
          ix_q    <= IX_WANT_VALUE;
        end
        IX_WANT_VALUE: ix_q <= IX_NONE;
        default:       ix_q <= IX_NONE;
      endcase
    end
  end

  // One register per delay; g=0 grace (enable), g=1 limit (reset).
  for (genvar g = 0; g < 2; g++) begin : g_dly
    localparam logic [7:0] HI_IX = (g == 0) ? IX_GRACE_HI : IX_LIMIT_HI;
    localparam logic [7:0] LO_IX = (g == 0) ? IX_GRACE_LO : IX_LIMIT_LO;
    logic [DLY_W-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q <= '0;
      end else if (val_wr && index_q == DATA_W'(HI_IX)) begin
        dly_q[DLY_W-1:DATA_W] <= acc_wdata;
      end else if (val_wr && index_q == DATA_W'(LO_IX)) begin
        dly_q[DATA_W-1:0] <= acc_wdata;
      end
    end
  end

  assign grace_dly = g_dly[0].dly_q;
  assign limit_dly = g_dly[1].dly_q;
endmodule

// File: rtl/cmdport_wdt_timer.sv
module cmdport_wdt_timer
  import cmdport_wdt_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tm_cmd_t          tm_cmd,
  input  logic [DLY_W-1:0] grace_dly,
  input  logic [DLY_W-1:0] limit_dly,
  output logic             active,
  output logic             rst_req,
  output logic             timed_out
);
  timeunit 1ns;
  timeprecision 1ps;

  tm_state_e        st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q <= DLY_W'(1));
  assign active    = (st_q != TM_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= TM_IDLE;
      cnt_q     <= '0;
      rst_req   <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (tm_cmd.stop) begin
        st_q  <= TM_IDLE;
        cnt_q <= '0;
      end else if (tm_cmd.start) begin
        timed_out <= 1'b0;
        if (grace_dly == '0) begin
          st_q  <= TM_ARMED;
          cnt_q <= limit_dly;
        end else begin
          st_q  <= TM_GRACE;
          cnt_q <= grace_dly;
        end
      end else if (tm_cmd.refresh && st_q == TM_ARMED) begin
        cnt_q <= limit_dly;
      end else if (tick) begin
        unique case (st_q)
          TM_GRACE: begin
            if (last_tick) begin
              st_q  <= TM_ARMED;
              cnt_q <= limit_dly;
            end else begin
              cnt_q <= cnt_q - DLY_W'(1);
            end
          end
          TM_ARMED: begin
            if (last_tick) begin
              st_q      <= TM_IDLE;
              cnt_q     <= '0;
              rst_req   <= 1'b1;
              timed_out <= 1'b1;
            end else begin
              cnt_q <= cnt_q - DLY_W'(1);
            end
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdport_wdt.sv
module cmdport_wdt
  import cmdport_wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DLY_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100ms,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wdt_active,
  output logic              wdt_rst_req,
  output logic              wdt_timeout
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              acc_fire;
  logic              acc_write;
  logic              acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] data_rd_byte;
  logic [DLY_W-1:0]  grace_dly;
  logic [DLY_W-1:0]  limit_dly;
  tm_cmd_t           tm_cmd;

  cmdport_wdt_port #(.DATA_W(DATA_W)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .data_rd_byte (data_rd_byte),
    .acc_fire     (acc_fire),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata)
  );

  cmdport_wdt_decode #(.DATA_W(DATA_W)) u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_fire     (acc_fire),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .data_rd_byte (data_rd_byte),
    .grace_dly    (grace_dly),
    .limit_dly    (limit_dly),
    .tm_cmd       (tm_cmd)
  );

  cmdport_wdt_timer #(.DLY_W(DLY_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_100ms),
    .tm_cmd    (tm_cmd),
    .grace_dly (grace_dly),
    .limit_dly (limit_dly),
    .active    (wdt_active),
    .rst_req   (wdt_rst_req),
    .timed_out (wdt_timeout)
  );
endmodule

// File: rtl/cmdport_wdt_chk.sv
module cmdport_wdt_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_100ms,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              wdt_active,
  input logic              wdt_rst_req,
  input logic              wdt_timeout
);
  timeunit 1ns;
  timeprecision 1ps;

  logic take;
  assign take = req_valid & req_ready;

  AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req); // R8
  AST_EXPIRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (!wdt_active && wdt_timeout)); // R8
  AST_EXPIRY_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(tick_100ms)); // R5
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && req_addr && req_wdata == DATA_W'(8'h28)) |=> (wdt_active && !wdt_timeout)); // R5
  AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && req_addr && req_wdata == DATA_W'(8'h29)) |=> (!wdt_active && !wdt_rst_req)); // R9
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write) |=> rsp_valid); // R12
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R12
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && req_addr) |=> (rsp_rdata == '0)); // R1
endmodule

bind cmdport_wdt cmdport_wdt_chk #(.DATA_W(DATA_W)) u_cmdport_wdt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_100ms  (tick_100ms),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .wdt_active  (wdt_active),
  .wdt_rst_req (wdt_rst_req),
  .wdt_timeout (wdt_timeout)
);

// File: tb/test_cmdport_wdt.sv
module test_cmdport_wdt;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100ms = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic       req_addr = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic       wdt_active;
  logic       wdt_rst_req;
  logic       wdt_timeout;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  cmdport_wdt i_cmdport_wdt (
    .clk(clk), .rst_n(rst_n), .tick_100ms(tick_100ms),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wdt_active(wdt_active), .wdt_rst_req(wdt_rst_req), .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_grace, m_limit, m_mode, m_left, m_ixstage, m_index;
  bit  m_ident, m_pend, m_req, m_tout;
  int  m_rdata;
  bit  take, opw, datw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_grace = 0; m_limit = 0; m_mode = 0; m_left = 0;
      m_ixstage = 0; m_index = 0; m_ident = 0; m_pend = 0;
      m_req = 0; m_tout = 0; m_rdata = 0;
    end else begin
      take = req_valid && !m_pend;
      opw  = take && req_write && req_addr;
      datw = take && req_write && !req_addr;
      m_req = 0;
      // timer first: it sees the delays as they were before this edge
      if (opw && req_wdata == 8'h29) begin
        m_mode = 0; m_left = 0;
      end else if (opw && req_wdata == 8'h28) begin
        m_tout = 0;
        if (m_grace == 0) begin m_mode = 2; m_left = m_limit; end
        else begin m_mode = 1; m_left = m_grace; end
      end else if (opw && req_wdata == 8'h2A && m_mode == 2) begin
        m_left = m_limit;
      end else if (tick_100ms) begin
        if (m_mode == 1) begin
          if (m_left <= 1) begin m_mode = 2; m_left = m_limit; end
          else m_left = m_left - 1;
        end else if (m_mode == 2) begin
          if (m_left <= 1) begin m_mode = 0; m_left = 0; m_req = 1; m_tout = 1; end
          else m_left = m_left - 1;
        end
      end
      // read response channel
      if (m_pend && rsp_ready) m_pend = 0;
      if (take && !req_write) begin
        m_pend = 1;
        m_rdata = req_addr ? 0 : (m_ident ? 'h95 : 0);
      end
      // command and indexed-write decode
      if (opw) begin
        m_ident   = (req_wdata == 8'h30);
        m_ixstage = (req_wdata == 8'h89) ? 1 : 0;
      end else if (datw) begin
        if (m_ixstage == 1) begin
          m_index = req_wdata; m_ixstage = 2;
        end else if (m_ixstage == 2) begin
          case (m_index)
            'h58: m_grace = (m_grace % 256) + req_wdata * 256;
            'h59: m_grace = (m_grace / 256) * 256 + req_wdata;
            'h5E: m_limit = (m_limit % 256) + req_wdata * 256;
            'h5F: m_limit = (m_limit / 256) * 256 + req_wdata;
            default: ;
          endcase
          m_ixstage = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == !m_pend, "R12 req_ready", req_ready, !m_pend);
      chk(rsp_valid == m_pend, "R12 rsp_valid", rsp_valid, m_pend);
      if (m_pend) chk(rsp_rdata == m_rdata[7:0], "R2 rsp_rdata", rsp_rdata, m_rdata);
      chk(wdt_active == (m_mode != 0), "R6 wdt_active", wdt_active, m_mode != 0);
      chk(wdt_rst_req == m_req, "R8 wdt_rst_req", wdt_rst_req, m_req);
      chk(wdt_timeout == m_tout, "R8 wdt_timeout", wdt_timeout, m_tout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic access(input bit wr, input bit a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic op(input logic [7:0] c);
    access(1'b1, 1'b1, c);
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    access(1'b0, a, 8'h00);
    v = rsp_rdata;
  endtask

  task automatic put(input logic [7:0] ix, input logic [7:0] v);
    op(8'h89);
    access(1'b1, 1'b0, ix);
    access(1'b1, 1'b0, v);
  endtask

  // Pulse n ticks; return the tick number after which rst_req was seen (0 = none).
  task automatic ticks(input int n, output int first);
    first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick_100ms = 1'b1;
      @(negedge clk); tick_100ms = 1'b0;
      if (wdt_rst_req && first == 0) first = i;
    end
  endtask

  task automatic expect_expiry(input int n, input string tag);
    int f;
    ticks(n + 2, f);
    chk(f == n, tag, f, n);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] v;
    int f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wdt_active && !wdt_timeout && !wdt_rst_req && !rsp_valid, "R13 idle after reset",
        {wdt_active, wdt_timeout, wdt_rst_req, rsp_valid}, 0);
    rd(1'b0, v); chk(v == 8'h00, "R13 data read after reset", v, 8'h00);
    rd(1'b1, v); chk(v == 8'h00, "R1 command address read", v, 8'h00);

    op(8'h30);
    rd(1'b0, v); chk(v == 8'h95, "R2 ident read", v, 8'h95);
    rd(1'b0, v); chk(v == 8'h95, "R2 ident read repeat", v, 8'h95);
    rd(1'b1, v); chk(v == 8'h00, "R1 command read after ident", v, 8'h00);
    op(8'h55);
    rd(1'b0, v); chk(v == 8'h00, "R11 unknown op clears ident", v, 8'h00);
    chk(!wdt_active, "R11 unknown op leaves timer idle", wdt_active, 0);

    put(8'h5E, 8'h00); put(8'h5F, 8'h03);
    op(8'h28);
    chk(wdt_active, "R6 active after start", wdt_active, 1);
    expect_expiry(3, "R5 expiry after reset delay");
    chk(wdt_timeout && !wdt_active, "R8 timeout latched and stopped", {wdt_timeout, wdt_active}, 2);

    op(8'h28);
    chk(!wdt_timeout && wdt_active, "R8 start clears timeout", {wdt_timeout, wdt_active}, 1);
    op(8'h29);
    chk(!wdt_active, "R9 stop is immediate", wdt_active, 0);
    ticks(6, f); chk(f == 0, "R9 no request after stop", f, 0);

    put(8'h59, 8'h02);
    op(8'h28);
    expect_expiry(5, "R5 enable delay then reset delay");
    op(8'h28);
    ticks(1, f);
    op(8'h2A);
    expect_expiry(4, "R7 refresh ignored during enable wait");

    put(8'h59, 8'h00); put(8'h5F, 8'h04);
    op(8'h28);
    ticks(2, f); chk(f == 0, "R7 no early expiry", f, 0);
    op(8'h2A);
    expect_expiry(4, "R7 refresh reloads reset delay");
    op(8'h2A);
    chk(!wdt_active, "R7 refresh while stopped", wdt_active, 0);
    ticks(3, f); chk(f == 0, "R7 refresh while stopped no request", f, 0);

    op(8'h28);
    ticks(1, f);
    put(8'h5F, 8'h01);
    expect_expiry(3, "R10 running count unchanged by write");
    op(8'h28);
    expect_expiry(1, "R10 new delay used at start");

    op(8'h89); access(1'b1, 1'b0, 8'h5F); op(8'h30); access(1'b1, 1'b0, 8'h07);
    access(1'b1, 1'b0, 8'h5F); access(1'b1, 1'b0, 8'h09);
    op(8'h28);
    expect_expiry(1, "R4 aborted and idle data writes ignored");
    op(8'h89); access(1'b1, 1'b0, 8'h58); op(8'h89);
    access(1'b1, 1'b0, 8'h5F); access(1'b1, 1'b0, 8'h02);
    op(8'h28);
    expect_expiry(2, "R4 indexed write restarts at index");

    put(8'h60, 8'h09);
    op(8'h28);
    expect_expiry(2, "R3 unknown index ignored");
    put(8'h5F, 8'h00); put(8'h5E, 8'h01);
    op(8'h28);
    expect_expiry(256, "R3 high byte of reset delay");
    put(8'h5E, 8'h00);
    op(8'h28);
    expect_expiry(1, "R5 zero reset delay acts as one");

    put(8'h5F, 8'h03);
    op(8'h28);
    ticks(2, f);
    op(8'h28);
    expect_expiry(3, "R9 start while active restarts");

    rsp_ready = 1'b0;
    op(8'h30);
    rd(1'b0, v);
    chk(rsp_valid && v == 8'h95, "R12 response presented", v, 8'h95);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 1'b1; req_wdata = 8'h28;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_rdata == 8'h95, "R12 response held under stall",
          {rsp_valid, req_ready}, 2);
    end
    req_valid = 1'b0; req_write = 1'b0;
    chk(!wdt_active, "R12 request not taken while pending", wdt_active, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12 response released", {rsp_valid, req_ready}, 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule